// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM Data Path

This block is the storage and data side of a synchronous static memory organised as four byte lanes. A control front end presents, every clock, whether an access is under way, its word address and whether that address was loaded by the processor-side strobe. The block turns the global write enable, the byte write enable and the per-lane enables into one write strobe per lane, and updates a parameterised array on the same rising edge.

Reads return through one of two latencies, picked by a static mode input. In the registered mode the word arrives one full cycle after the address edge. In the flow-through mode it arrives within the cycle after the address edge, through a single register. The block also produces the drive enable for the shared data bus. This enable follows an asynchronous output enable, turns the bus around on writes, drops one cycle after a deselect and stays low while a snooze input holds the block idle with its contents kept. Each lane is eight bits, plus an optional ninth parity bit, so a word is 32 or 36 bits wide.

Top module: `bwsram_dp`

## Requirements
- R1: With `acc_vld` high, `acc_pstrobe` low and `gwe_n` low, every lane of the word at `acc_addr` takes `wdata` on that edge, whatever `bwe_n` and `be_n` are.
- R2: With `gwe_n` high and `bwe_n` low, exactly the lanes whose `be_n` bit is low are written. Lane i is bits [9i+8:9i] of the 36-bit word. The other lanes keep their contents.
- R3: With `gwe_n` high, `bwe_n` low and all of `be_n` high, the cycle is a read of `acc_addr` and no lane changes.
- R4: With `gwe_n` high and `bwe_n` high, the cycle is a read and no lane changes.
- R5: On an edge where `acc_pstrobe` is high, all write enables are ignored. The cycle is a read and the array is not modified.
- R6: With `flow_n` high, a read sampled on edge k shows its word on `rdata` with `dq_oe` high in the cycle after edge k+1, and not in the cycle after edge k.
- R7: With `flow_n` low, a read sampled on edge k shows its word on `rdata` with `dq_oe` high in the cycle after edge k.
- R8: `dq_oe` is high only while `oe_n` is low and a read word is in the output stage. `oe_n` acts without waiting for a clock edge.
- R9: After an edge that samples a write, `dq_oe` is low for the following cycle even if `oe_n` is low.
- R10: After an edge with `acc_vld` low, `dq_oe` is low in the next cycle in flow-through mode. In registered mode it is low after one further idle edge.
- R11: While `snooze` is high, no access is accepted and `dq_oe` is low. Stored words are kept.
- R12: While reset is asserted and right after reset, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_vld | input | 1 | Access in progress this cycle (chip selected) |
| acc_addr | input | AW | Word address of the access |
| acc_pstrobe | input | 1 | Address loaded by the processor-side strobe on this edge |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| be_n | input | LANES | Per-lane enables, active low |
| wdata | input | W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_n | input | 1 | Static latency select: low gives flow-through, high gives registered |
| snooze | input | 1 | Low-power hold: blocks accesses and keeps the data |
| rdata | output | W | Read data toward the bus driver |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench targets a read followed at once by a write. A design that skipped the turnaround would drive the bus with stale pipelined data while the controller drives write data. It also writes with only some lanes enabled and then reads back. A wrong lane decode would show up as a merged word with the wrong byte changed. A processor-strobe edge is presented with every write enable active. A design that honoured the enables there would corrupt the word, and the next read exposes it. The bench also checks the latency of each mode, the single idle cycle before the bus releases, the asynchronous response to the output enable and a write attempted during snooze. Any of these slips makes the output enable or the data differ from the behavioural model on some clock.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bwsram_wen.sv
module bwsram_wen
  import bwsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             acc_vld,
  input  logic             acc_pstrobe,
  input  logic             snooze,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] be_n,
  output logic [LANES-1:0] lane_we,
  output op_e              op
);
  // Global enable wins over the byte enables; processor-strobe edges are reads.
  always_comb begin
    lane_we = '0;
    op      = OP_IDLE;
    if (acc_vld && !snooze) begin
      op = OP_READ;
      if (!acc_pstrobe) begin
        if (!gwe_n)      lane_we = '1;
        else if (!bwe_n) lane_we = ~be_n;
        if (|lane_we)    op = OP_WRITE;
      end
    end
  end
endmodule

// File: rtl/bwsram_array.sv
module bwsram_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[raddr];
  end
endmodule

// File: rtl/bwsram_rdpath.sv
module bwsram_rdpath
  import bwsram_pkg::*;
#(
  parameter int W  = 36,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic          flow_n,
  input  logic          oe_n,
  input  logic          snooze,
  input  logic [W-1:0]  arr_rdata,
  output logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          dq_oe
);
  logic [AW-1:0] addr_q, addr_d;
  logic          rd_q, rd_d;
  logic          wr_q, wr_d;
  logic          pv_q, pv_d;
  logic [W-1:0]  pd_q, pd_d;
  logic          pd_en;
  logic          stage_vld;

  always_comb begin
    addr_d = (op != OP_IDLE) ? addr : addr_q;
    rd_d   = (op == OP_READ);
    wr_d   = (op == OP_WRITE);
    pv_d   = rd_q;
    pd_en  = rd_q;
    pd_d   = arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      pv_q   <= 1'b0;
      pd_q   <= '0;
    end else begin
      addr_q <= addr_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      pv_q   <= pv_d;
      if (pd_en) pd_q <= pd_d;
    end
  end

  assign raddr     = addr_q;
  assign stage_vld = flow_n ? pv_q : rd_q;
  assign rdata     = flow_n ? pd_q : arr_rdata;
  assign dq_oe     = stage_vld && !wr_q && !oe_n && !snooze;
endmodule

// File: rtl/bwsram_dp.sv
module bwsram_dp
  import bwsram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PARITY = 1,
  parameter int DEPTH  = 256,
  localparam int LANE_W = 8 + PARITY,
  localparam int W      = LANES * LANE_W,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_pstrobe,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] be_n,
  input  logic [W-1:0]     wdata,
  input  logic             oe_n,
  input  logic             flow_n,
  input  logic             snooze,
  output logic [W-1:0]     rdata,
  output logic             dq_oe
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [LANES-1:0] lane_we;
  op_e              op;
  logic [AW-1:0]    raddr;
  logic [W-1:0]     arr_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bwsram_wen #(.LANES(LANES)) u_wen (
    .acc_vld     (acc_vld),
    .acc_pstrobe (acc_pstrobe),
    .snooze      (snooze),
    .gwe_n       (gwe_n),
    .bwe_n       (bwe_n),
    .be_n        (be_n),
    .lane_we     (lane_we),
    .op          (op)
  );

  bwsram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_array (
    .clk   (clk),
    .we    (lane_we),
    .waddr (acc_addr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (arr_rdata)
  );

  bwsram_rdpath #(.W(W), .AW(AW)) u_rdpath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .op        (op),
    .addr      (acc_addr),
    .flow_n    (flow_n),
    .oe_n      (oe_n),
    .snooze    (snooze),
    .arr_rdata (arr_rdata),
    .raddr     (raddr),
    .rdata     (rdata),
    .dq_oe     (dq_oe)
  );
endmodule

// File: rtl/bwsram_dp_chk.sv
module bwsram_dp_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_vld,
  input logic acc_pstrobe,
  input logic gwe_n,
  input logic oe_n,
  input logic flow_n,
  input logic snooze,
  input logic dq_oe
);
  always_comb begin
    if (!rst_n) assert_reset_quiet_R12: assert (!dq_oe);
  end

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  assert_snooze_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !dq_oe);

  assert_write_turn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !snooze && !acc_pstrobe && !gwe_n) |=> !dq_oe);

  assert_flow_desel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_vld && !flow_n) |=> (!dq_oe || flow_n));

  assert_pipe_desel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_n && !acc_vld && $past(!acc_vld) && $past(flow_n)) |=> (!dq_oe || !flow_n));

  assert_pstrobe_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_pstrobe && !snooze && !flow_n)
      |=> (dq_oe || oe_n || snooze || flow_n));
endmodule

bind bwsram_dp bwsram_dp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_vld     (acc_vld),
  .acc_pstrobe (acc_pstrobe),
  .gwe_n       (gwe_n),
  .oe_n        (oe_n),
  .flow_n      (flow_n),
  .snooze      (snooze),
  .dq_oe       (dq_oe)
);

// File: tb/sim_bwsram_dp.sv
`timescale 1ns/100ps
module sim_bwsram_dp;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int W  = 36;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_vld, acc_pstrobe, gwe_n, bwe_n, oe_n, flow_n, snooze;
  logic [AW-1:0] acc_addr;
  logic [LN-1:0] be_n;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic          dq_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bwsram_dp u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .acc_pstrobe(acc_pstrobe), .gwe_n(gwe_n), .bwe_n(bwe_n), .be_n(be_n),
    .wdata(wdata), .oe_n(oe_n), .flow_n(flow_n), .snooze(snooze),
    .rdata(rdata), .dq_oe(dq_oe)
  );

  // Behavioural reference model
  logic [W-1:0] mref [256];
  logic [W:0]   pq[$];
  bit           m_rd, m_wr;
  int           m_addr;

  always @(posedge clk) begin
    logic [LN-1:0] we;
    bit            acc, rd_now;
    if (!rst_n) begin
      m_rd = 0; m_wr = 0; m_addr = 0;
      pq.delete();
      pq.push_back('0);
    end else begin
      pq.push_back({m_rd, mref[m_addr]});
      if (pq.size() > 1) void'(pq.pop_front());
      we  = '0;
      acc = acc_vld && !snooze;
      if (acc && !acc_pstrobe) begin
        if (!gwe_n)      we = '1;
        else if (!bwe_n) we = ~be_n;
      end
      rd_now = acc && (we == '0);
      for (int i = 0; i < LN; i++)
        if (we[i]) mref[acc_addr][i*LW +: LW] = wdata[i*LW +: LW];
      if (acc) m_addr = acc_addr;
      m_rd = rd_now;
      m_wr = (we != '0);
    end
  end

  // Per-clock comparison against the model
  always @(posedge clk) begin
    bit           eo;
    logic [W-1:0] ed;
    #4;
    if (rst_n && !done) begin
      if (flow_n) begin eo = pq[0][W]; ed = pq[0][W-1:0]; end
      else        begin eo = m_rd;     ed = mref[m_addr];  end
      eo = eo && !m_wr && !oe_n && !snooze;
      checks++;
      if (dq_oe !== eo || (eo && rdata !== ed)) begin
        errors++;
        $display("FAIL R8 model oe=%0b exp %0b data=%h exp %h", dq_oe, eo, rdata, ed);
      end
    end
  end

  task automatic chk(string tag, bit eo, logic [W-1:0] ed);
    checks++;
    if (dq_oe !== eo || (eo && rdata !== ed)) begin
      errors++;
      $display("FAIL %s oe=%0b exp %0b data=%h exp %h", tag, dq_oe, eo, rdata, ed);
    end
  endtask

  task automatic cyc(bit v, int a, bit ps, bit g, bit b, logic [LN-1:0] e, logic [W-1:0] d);
    @(negedge clk);
    acc_vld = v; acc_addr = a[AW-1:0]; acc_pstrobe = ps;
    gwe_n = g; bwe_n = b; be_n = e; wdata = d;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [W-1:0] merge(logic [W-1:0] o, logic [W-1:0] n, logic [LN-1:0] en_n);
    logic [W-1:0] r = o;
    for (int i = 0; i < LN; i++) if (!en_n[i]) r[i*LW +: LW] = n[i*LW +: LW];
    return r;
  endfunction

  localparam logic [W-1:0] WA = 36'h1_2345_6789;
  localparam logic [W-1:0] WB = 36'hE_DCBA_9876;
  localparam logic [W-1:0] WC = 36'h5_5555_5555;
  localparam logic [W-1:0] WD = 36'hA_F0F0_3C3C;
  localparam logic [W-1:0] WE = 36'h0_0000_0FFF;

  initial begin
    logic [W-1:0] mab;
    mab = merge(WA, WB, 4'b1010);
    rst_n = 1'b0; acc_vld = 0; acc_addr = '0; acc_pstrobe = 0;
    gwe_n = 1; bwe_n = 1; be_n = '1; wdata = '0;
    oe_n = 0; flow_n = 1; snooze = 0;
    repeat (3) @(posedge clk);
    #2 chk("R12 in reset", 0, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 chk("R12 after reset", 0, '0);

    cyc(1, 5, 0, 0, 0, 4'b0000, WA);  chk("R9 write gap", 0, '0);
    cyc(1, 5, 0, 1, 1, 4'b0000, '0);  chk("R6 not yet", 0, '0);
    cyc(0, 0, 0, 1, 1, 4'hF, '0);     chk("R1 full word R6 latency R4", 1, WA);
    cyc(0, 0, 0, 1, 1, 4'hF, '0);     chk("R10 pipe release", 0, '0);

    cyc(1, 5, 0, 1, 0, 4'b1010, WB);
    cyc(1, 5, 0, 1, 0, 4'b1111, WC);
    cyc(0, 0, 0, 1, 1, 4'hF, '0);     chk("R2 lane merge R3 no-lane read", 1, mab);

    cyc(1, 5, 1, 0, 0, 4'b0000, WC);
    cyc(0, 0, 0, 1, 1, 4'hF, '0);     chk("R5 pstrobe is read", 1, mab);

    cyc(1, 5, 0, 1, 1, 4'hF, '0);
    cyc(1, 6, 0, 0, 1, 4'hF, WD);     chk("R9 turnaround", 0, '0);
    cyc(0, 0, 0, 1, 1, 4'hF, '0);     chk("R9 write not read", 0, '0);
    cyc(1, 6, 0, 1, 1, 4'hF, '0);
    cyc(0, 0, 0, 1, 1, 4'hF, '0);     chk("R1 second word", 1, WD);

    cyc(1, 6, 0, 1, 1, 4'hF, '0);
    @(negedge clk) begin acc_vld = 0; oe_n = 1; end
    @(posedge clk); #2 chk("R8 oe high", 0, '0);
    oe_n = 0; #1 chk("R8 oe async", 1, WD);

    cyc(0, 0, 0, 1, 1, 4'hF, '0);
    @(negedge clk) flow_n = 0;
    cyc(1, 5, 0, 1, 1, 4'hF, '0);     chk("R7 flow latency", 1, mab);
    cyc(0, 0, 0, 1, 1, 4'hF, '0);     chk("R10 flow release", 0, '0);

    @(negedge clk) snooze = 1;
    cyc(1, 5, 0, 0, 0, 4'b0000, WE);  chk("R11 snooze write", 0, '0);
    cyc(1, 5, 0, 1, 1, 4'hF, '0);     chk("R11 snooze read", 0, '0);
    @(negedge clk) snooze = 0;
    cyc(1, 5, 0, 1, 1, 4'hF, '0);     chk("R11 data kept", 1, mab);
    cyc(0, 0, 0, 1, 1, 4'hF, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200_000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule